// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store of `WORDS` entries, each `WIDTH` bits wide, that is looked up by content instead of by address. A search presents an argument word and a key word. Every occupied entry is compared with the argument in the same clock, and only the bit positions where the key holds a 1 take part in the comparison. The outcome is a registered match vector with one bit per entry. From that vector the block derives an any-match flag, a several-match flag, and a read of the lowest-numbered matching entry together with its index.

Writes carry no address. Each entry has an occupancy bit. A write stores the argument word into the lowest-numbered free entry and reports which entry it used. When every entry is occupied the write is refused and a full flag is raised. A clear command frees every entry whose bit is set in the current match vector, so a search followed by a clear removes all entries that fit a masked pattern.

Top module: `cam_masked`

## Requirements
- R1: After reset the match vector is all zeros, `full` is 0, `wr_ack` and `wr_reject` are 0, `rd_data` is zero, and no entry is occupied, so any later search finds nothing until a write has been accepted.
- R2: A search (`op_valid`=1, `op_code`=2'd1) updates `match_vec` at the next clock edge. Bit i becomes 1 exactly when entry i is occupied and agrees with `arg_in` at every position where `key_in` is 1.
- R3: Positions where `key_in` is 0 have no effect on the match result. A key of all zeros matches every occupied entry.
- R4: A key of all ones needs every bit of an occupied entry to equal `arg_in` before that entry matches.
- R5: A write (`op_code`=2'd2) with a free entry stores `arg_in` into the lowest-numbered free entry. At the next edge it gives a one-cycle `wr_ack` with that entry's number on `wr_index`. `match_vec` is left unchanged.
- R6: `full` is 1 exactly when every entry is occupied. A write while full gives a one-cycle `wr_reject`, does not give `wr_ack`, and changes no stored entry.
- R7: A free entry never has its bit set in `match_vec`, whatever argument and key are used.
- R8: `match_any` is 1 when at least one bit of `match_vec` is set. `match_multi` is 1 when two or more bits are set.
- R9: `rd_data` holds the contents of the lowest-numbered entry whose bit is set in `match_vec`, and `rd_index` holds that entry's number. When no bit is set, `rd_data` is zero.
- R10: A clear (`op_code`=2'd3) frees every entry whose bit is set in `match_vec` and zeroes `match_vec` at the next edge. A later write can reuse the freed entries, lowest number first.
- R11: A command is taken only when `op_valid` is 1. With `op_valid` at 0, or with `op_code`=2'd0, nothing is stored, freed or searched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 2 | 0 idle, 1 search, 2 write, 3 clear |
| arg_in | input | WIDTH | Search argument or write data |
| key_in | input | WIDTH | Per-bit compare enable for a search |
| match_vec | output | WORDS | Registered match vector |
| match_any | output | 1 | At least one match |
| match_multi | output | 1 | Two or more matches |
| rd_data | output | WIDTH | Contents of the lowest-numbered matching entry |
| rd_index | output | $clog2(WORDS) | Number of that entry |
| full | output | 1 | Every entry occupied |
| wr_ack | output | 1 | One-cycle pulse when a write is accepted |
| wr_reject | output | 1 | One-cycle pulse when a write is refused |
| wr_index | output | $clog2(WORDS) | Entry used by the last accepted write |

## Verification
Every command is registered by one clock edge. `match_vec`, `wr_ack`, `wr_reject`, `wr_index` and the occupancy behind `full` therefore change at the edge that samples the command. `match_any`, `match_multi`, `rd_data` and `rd_index` follow combinationally from that same state. The bench drives each command on a falling edge and removes it just after the next rising edge. It updates its own model of the entries, the occupancy and the match vector as if that edge had occurred, and compares all outputs one nanosecond later, inside the cycle that the edge produced. Pulse outputs are checked in that cycle only, so a pulse that arrives a cycle late or lasts too long is also reported.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_SEARCH = 2'd1,
        CMD_WRITE  = 2'd2,
        CMD_CLEAR  = 2'd3
    } cam_cmd_e;

    typedef struct packed {
        logic search;
        logic write;
        logic clear;
    } cam_strobe_t;

    function automatic cam_strobe_t decode_cmd(input logic valid, input cam_cmd_e cmd);
        cam_strobe_t s;
        s.search = valid && (cmd == CMD_SEARCH);
        s.write  = valid && (cmd == CMD_WRITE);
        s.clear  = valid && (cmd == CMD_CLEAR);
        return s;
    endfunction

endpackage

// File: rtl/cam_word_match.sv
module cam_word_match #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] stored,
    input  logic             occupied,
    input  logic [WIDTH-1:0] arg,
    input  logic [WIDTH-1:0] key,
    output logic             hit
);
    logic [WIDTH-1:0] diff_bits;

    assign diff_bits = (stored ^ arg) & key;
    assign hit       = occupied && (diff_bits == '0);
endmodule

// File: rtl/cam_first_set.sv
module cam_first_set #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end

    // R9 / R5: the chosen position is a set request bit, and no lower one is set
    always_comb begin
        if (found) begin
            p_pick_is_set_r9: assert (req[idx]);
            p_pick_is_lowest_r9: assert ((req & ((N'(1) << idx) - N'(1))) == '0);
        end
    end
endmodule

// File: rtl/cam_masked.sv
module cam_masked
    import cam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [WIDTH-1:0] arg_in,
    input  logic [WIDTH-1:0] key_in,
    output logic [WORDS-1:0] match_vec,
    output logic             match_any,
    output logic             match_multi,
    output logic [WIDTH-1:0] rd_data,
    output logic [IW-1:0]    rd_index,
    output logic             full,
    output logic             wr_ack,
    output logic             wr_reject,
    output logic [IW-1:0]    wr_index
);
    logic [WIDTH-1:0] mem_q [WORDS];
    logic [WORDS-1:0] occ_q;
    logic [WORDS-1:0] match_q;
    logic [WORDS-1:0] hits;
    logic             ack_q, rej_q;
    logic [IW-1:0]    widx_q;

    cam_strobe_t      strobe;
    logic             free_found;
    logic [IW-1:0]    free_idx;
    logic             hit_found;
    logic [IW-1:0]    hit_idx;

    assign strobe = decode_cmd(op_valid, cam_cmd_e'(op_code));

    // parallel compare lanes, one per entry
    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        cam_word_match #(.WIDTH(WIDTH)) u_cmp (
            .stored   (mem_q[g]),
            .occupied (occ_q[g]),
            .arg      (arg_in),
            .key      (key_in),
            .hit      (hits[g])
        );
    end

    // allocation: lowest free entry
    cam_first_set #(.N(WORDS), .IW(IW)) u_free (
        .req   (~occ_q),
        .found (free_found),
        .idx   (free_idx)
    );

    // read: lowest matching entry
    cam_first_set #(.N(WORDS), .IW(IW)) u_hit (
        .req   (match_q),
        .found (hit_found),
        .idx   (hit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q   <= '0;
            match_q <= '0;
            ack_q   <= 1'b0;
            rej_q   <= 1'b0;
            widx_q  <= '0;
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            ack_q <= 1'b0;
            rej_q <= 1'b0;
            if (strobe.search) begin
                match_q <= hits;
            end
            if (strobe.write) begin
                if (free_found) begin
                    mem_q[free_idx] <= arg_in;
                    occ_q[free_idx] <= 1'b1;
                    ack_q           <= 1'b1;
                    widx_q          <= free_idx;
                end else begin
                    rej_q <= 1'b1;
                end
            end
            if (strobe.clear) begin
                occ_q   <= occ_q & ~match_q;
                match_q <= '0;
            end
        end
    end

    assign match_vec   = match_q;
    assign match_any   = hit_found;
    assign match_multi = (match_q & (match_q - WORDS'(1))) != '0;
    assign rd_data     = hit_found ? mem_q[hit_idx] : '0;
    assign rd_index    = hit_idx;
    assign full        = &occ_q;
    assign wr_ack      = ack_q;
    assign wr_reject   = rej_q;
    assign wr_index    = widx_q;

    // R7: a free entry never shows a match
    p_free_never_hits_r7: assert property (@(posedge clk) disable iff (rst)
        (match_q & ~occ_q) == '0);

    // R6: a write while full is refused and leaves occupancy alone
    p_reject_when_full_r6: assert property (@(posedge clk) disable iff (rst)
        (strobe.write && full) |=> (rej_q && !ack_q && $stable(occ_q)));

    // R5: an accepted write occupies exactly one more entry
    p_write_adds_one_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe.write && !full && !strobe.clear) |=>
            ($countones(occ_q) == $countones($past(occ_q)) + 1));

    // R10: clear frees every matched entry and empties the match vector
    p_clear_frees_r10: assert property (@(posedge clk) disable iff (rst)
        strobe.clear |=> (((occ_q & $past(match_q)) == '0) && (match_q == '0)));

    // R8: several matches imply at least one
    p_multi_has_any_r8: assert property (@(posedge clk) disable iff (rst)
        match_multi |-> match_any);

    // R11: with no strobe, state holds
    p_idle_holds_r11: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(occ_q) && $stable(match_q) && !ack_q && !rej_q));
endmodule

// File: tb/cam_masked_tb.sv
module cam_masked_tb;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          op_valid;
    logic [1:0]    op_code;
    logic [W-1:0]  arg_in, key_in;
    logic [N-1:0]  match_vec;
    logic          match_any, match_multi, full, wr_ack, wr_reject;
    logic [W-1:0]  rd_data;
    logic [IW-1:0] rd_index, wr_index;

    int n_checks = 0;
    int n_fails  = 0;

    logic [W-1:0]  exp_mem [N];
    logic [N-1:0]  exp_occ;
    logic [N-1:0]  exp_m;
    logic          exp_ack, exp_rej;
    logic [IW-1:0] exp_widx;

    always #2.5 clk = ~clk;

    cam_masked #(.WORDS(N), .WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .arg_in(arg_in), .key_in(key_in), .match_vec(match_vec),
        .match_any(match_any), .match_multi(match_multi), .rd_data(rd_data),
        .rd_index(rd_index), .full(full), .wr_ack(wr_ack),
        .wr_reject(wr_reject), .wr_index(wr_index)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_hits(input logic [W-1:0] a, input logic [W-1:0] k);
        logic [N-1:0] h;
        for (int i = 0; i < N; i++)
            h[i] = exp_occ[i] && (((exp_mem[i] ^ a) & k) == '0);
        return h;
    endfunction

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check_all(input string ctx);
        int lo;
        lo = lowest(exp_m);
        chk({ctx, " R2"}, "match_vec", 32'(match_vec), 32'(exp_m));
        chk({ctx, " R6"}, "full", 32'(full), 32'(&exp_occ));
        chk({ctx, " R5"}, "wr_ack", 32'(wr_ack), 32'(exp_ack));
        chk({ctx, " R6"}, "wr_reject", 32'(wr_reject), 32'(exp_rej));
        if (exp_ack) chk({ctx, " R5"}, "wr_index", 32'(wr_index), 32'(exp_widx));
        chk({ctx, " R8"}, "match_any", 32'(match_any), 32'(exp_m != '0));
        chk({ctx, " R8"}, "match_multi", 32'(match_multi), 32'($countones(exp_m) > 1));
        if (lo >= 0) begin
            chk({ctx, " R9"}, "rd_data", 32'(rd_data), 32'(exp_mem[lo]));
            chk({ctx, " R9"}, "rd_index", 32'(rd_index), 32'(lo));
        end else begin
            chk({ctx, " R9"}, "rd_data", 32'(rd_data), 32'h0);
        end
    endtask

    task automatic do_op(input string ctx, input logic v, input logic [1:0] c,
                         input logic [W-1:0] a, input logic [W-1:0] k);
        int f;
        @(negedge clk);
        op_valid = v; op_code = c; arg_in = a; key_in = k;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        exp_ack = 1'b0;
        exp_rej = 1'b0;
        if (v) begin
            case (c)
                2'd1: exp_m = model_hits(a, k);
                2'd2: begin
                    f = lowest(~exp_occ);
                    if (f >= 0) begin
                        exp_mem[f] = a; exp_occ[f] = 1'b1;
                        exp_ack = 1'b1; exp_widx = IW'(f);
                    end else begin
                        exp_rej = 1'b1;
                    end
                end
                2'd3: begin exp_occ = exp_occ & ~exp_m; exp_m = '0; end
                default: ;
            endcase
        end
        check_all(ctx);
    endtask

    initial begin
        #(5ns * 200000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1; op_valid = 1'b0; op_code = '0; arg_in = '0; key_in = '0;
        for (int i = 0; i < N; i++) exp_mem[i] = '0;
        exp_occ = '0; exp_m = '0; exp_ack = 0; exp_rej = 0; exp_widx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        check_all("R1 reset");
        do_op("R1 empty search R7", 1'b1, 2'd1, 16'h0000, 16'h0000);
        // R11: write code without strobe, then idle code with strobe
        do_op("R11 no strobe", 1'b0, 2'd2, 16'h1111, 16'hFFFF);
        do_op("R11 idle code", 1'b1, 2'd0, 16'h2222, 16'hFFFF);
        do_op("R11 verify", 1'b1, 2'd1, 16'h0000, 16'h0000);
        // R5 fill in order, entry 6 duplicates entry 2
        for (int i = 0; i < N; i++)
            do_op("R5 fill", 1'b1, 2'd2, (i == 6) ? 16'hA5C2 : (16'hA5C0 | 16'(i)), 16'h0);
        do_op("R6 write when full", 1'b1, 2'd2, 16'hBEEF, 16'h0);
        do_op("R6 contents kept R4", 1'b1, 2'd1, 16'hBEEF, 16'hFFFF);
        do_op("R4 exact dup R8", 1'b1, 2'd1, 16'hA5C2, 16'hFFFF);
        do_op("R3 masked low nibble", 1'b1, 2'd1, 16'hA5C9, 16'hFFF0);
        do_op("R3 zero key", 1'b1, 2'd1, 16'h1234, 16'h0000);
        do_op("R4 exact single", 1'b1, 2'd1, 16'hA5C3, 16'hFFFF);
        do_op("R10 clear", 1'b1, 2'd3, 16'h0, 16'h0);
        do_op("R10 reuse", 1'b1, 2'd2, 16'h7777, 16'h0);
        do_op("R10 dup search", 1'b1, 2'd1, 16'hA5C2, 16'hFFFF);
        do_op("R10 clear two", 1'b1, 2'd3, 16'h0, 16'h0);
        do_op("R10 reuse low", 1'b1, 2'd2, 16'h0102, 16'h0);
        do_op("R7 freed no hit", 1'b1, 2'd1, 16'hA5C0, 16'hFFF0);
        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [1:0] c;
            logic [W-1:0] a, k;
            r = int'($urandom % 100);
            c = (r < 50) ? 2'd1 : (r < 80) ? 2'd2 : (r < 90) ? 2'd3 : 2'd0;
            a = 16'($urandom) & 16'h0303;
            case ($urandom % 3)
                0: k = 16'hFFFF;
                1: k = 16'h0000;
                default: k = 16'($urandom);
            endcase
            do_op("R2 random", ($urandom % 8) != 0, c, a, k);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule